// File: doc/BRIEF.md
# Phrase Load/Store Unit with Shared High-Word Register

This unit sits between a 32-bit coprocessor core and a 64-bit external memory port. Besides ordinary 32-bit loads and stores it offers 64-bit phrase accesses. A single high-word holding register, which the core can read and write, supplies the upper half of every phrase store and receives the upper half of every external load. An address with its top bit set falls in a small internal word memory. Such accesses finish in one cycle and never touch the external port or the holding register.

External accesses run at the controller's own pace. The controller accepts an access and waits a fixed launch delay, standing in for bus arbitration. It then starts the external transfer, and only at that point does it capture the store data. It holds the request until the memory acknowledges. While an external access is pending, any further external request from the core is stalled. Internal accesses and holding-register operations go ahead. A core that rewrites the holding register before a pending phrase store has launched therefore changes what that store writes.

Top module: `phr_unit`

## Requirements
- R1: After reset, `stall`, `mem_req`, `int_rvalid` and `ext_rvalid` are low, and a high-word read (op 5) returns 0.
- R2: Op 4 writes `req_wdata` into the high-word register. Op 5 returns its value on `int_rdata` with `int_rvalid` one cycle after acceptance. Neither op ever stalls.
- R3: A phrase store (op 3) to an external address writes one 64-bit word. Bits 63:32 hold the high-word register as it stands at launch, and bits 31:0 hold `req_wdata`. `mem_be` is 8'hFF and `mem_addr` has its low three bits cleared, whatever bits 2:0 of the request address were.
- R4: A phrase load (op 2) from an external address returns `mem_rdata[31:0]` on `ext_rdata` with `ext_rvalid` one cycle after the acknowledge. It loads `mem_rdata[63:32]` into the high-word register.
- R5: An ordinary external load (op 0) returns the 32-bit lane picked by address bit 2 (1 = upper). It also overwrites the high-word register with `mem_rdata[63:32]`.
- R6: An ordinary external store (op 1) drives the data on both lanes of `mem_wdata`. `mem_be` is 8'hF0 when address bit 2 is 1 and 8'h0F when it is 0.
- R7: Loads and stores to addresses with the top bit set go to internal word memory. A load answers on `int_rdata` one cycle after acceptance. Ops 2 and 3 behave there like ops 0 and 1. No external request is raised, no stall occurs, and the high-word register is unchanged.
- R8: An external request issued while an earlier external access is still pending is stalled until that access has been acknowledged. It then sees the earlier access's effect.
- R9: Phrase store data is captured only at launch, LAUNCH_CYC cycles after acceptance. A high-word write accepted in the cycle right after the phrase store reaches that store. A high-word write issued after a later external access has been accepted never does.
- R10: Op codes 6 and 7 are ignored: no response, no external request, and the high-word register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 3 | 0 load, 1 store, 2 phrase load, 3 phrase store, 4 write high word, 5 read high word |
| req_addr | input | AW | Byte address; top bit selects internal memory |
| req_wdata | input | 32 | Store data or high-word value |
| stall | output | 1 | Request not accepted this cycle |
| int_rvalid | output | 1 | Internal/high-word read data valid |
| int_rdata | output | 32 | Internal/high-word read data |
| ext_rvalid | output | 1 | External load data valid |
| ext_rdata | output | 32 | External load data |
| mem_req | output | 1 | External transfer request, held until acknowledge |
| mem_we | output | 1 | External transfer is a write |
| mem_addr | output | AW | Phrase-aligned external address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 64 | Read data, valid with acknowledge |

## Verification
Phrase stores are swept over eight phrase addresses times all eight low-address offsets. Each case uses a distinct high-word value, so the sweep shows both the address masking and the pairing of the high word with the low word. Ordinary loads hit both lanes with a different value preloaded in the holding register, which separates lane selection from the high-word overwrite. Internal accesses run in a loop over every internal word while the external request count is watched. The ordering tests issue a high-word write at two points: directly after a phrase store, and after a stalled intervening external access. This tells launch-time capture apart from issue-time capture.

// File: rtl/phr_pkg.sv
package phr_pkg;
    typedef enum logic [2:0] {
        OP_LD   = 3'd0,
        OP_ST   = 3'd1,
        OP_LDP  = 3'd2,
        OP_STP  = 3'd3,
        OP_HWR  = 3'd4,
        OP_HRD  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } phr_op_e;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_WAIT = 2'd1,
        CT_XFER = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/phr_int_ram.sv
module phr_int_ram #(
    parameter int WORDS = 16,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[idx] <= wdata;
        if (rd_en) rdata <= words_q[idx];
    end
endmodule

// File: rtl/phr_ext_ctrl.sv
module phr_ext_ctrl
    import phr_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LAUNCH_CYC = 2,
    localparam int CW = $clog2(LAUNCH_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic          start_phrase,
    input  logic [AW-1:2] start_addr,
    input  logic [31:0]   start_data,
    input  logic [31:0]   hi_word,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_be,
    output logic [63:0]   mem_wdata,
    output logic          ld_done,
    output logic [31:0]   ld_word,
    output logic [31:0]   ld_upper
);
    typedef struct packed {
        ctl_state_e    state;
        logic [CW-1:0] cnt;
        logic          we;
        logic          phrase;
        logic          lane;
        logic [AW-1:0] paddr;
        logic [31:0]   low;
        logic [63:0]   wdata;
        logic [7:0]    be;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        ld_done = 1'b0;
        case (c_q.state)
            CT_IDLE: begin
                if (start) begin
                    c_d.state  = CT_WAIT;
                    c_d.cnt    = CW'(LAUNCH_CYC);
                    c_d.we     = start_we;
                    c_d.phrase = start_phrase;
                    c_d.lane   = start_addr[2];
                    c_d.paddr  = {start_addr[AW-1:3], 3'b000};
                    c_d.low    = start_data;
                end
            end
            CT_WAIT: begin
                // launch point: store data is sampled here, not at acceptance
                if (c_q.cnt <= CW'(1)) begin
                    c_d.state = CT_XFER;
                    c_d.wdata = c_q.phrase ? {hi_word, c_q.low} : {c_q.low, c_q.low};
                    c_d.be    = c_q.phrase ? 8'hFF : (c_q.lane ? 8'hF0 : 8'h0F);
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            CT_XFER: begin
                if (mem_ack) begin
                    c_d.state = CT_IDLE;
                    ld_done   = !c_q.we;
                end
            end
            default: c_d.state = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy      = (c_q.state != CT_IDLE);
    assign mem_req   = (c_q.state == CT_XFER);
    assign mem_we    = c_q.we;
    assign mem_addr  = c_q.paddr;
    assign mem_be    = c_q.be;
    assign mem_wdata = c_q.wdata;
    assign ld_upper  = mem_rdata[63:32];
    assign ld_word   = (c_q.phrase || !c_q.lane) ? mem_rdata[31:0] : mem_rdata[63:32];
endmodule

// File: rtl/phr_unit.sv
module phr_unit
    import phr_pkg::*;
#(
    parameter int AW         = 16,
    parameter int INT_WORDS  = 16,
    parameter int LAUNCH_CYC = 2,
    localparam int IW = $clog2(INT_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          stall,
    output logic          int_rvalid,
    output logic [31:0]   int_rdata,
    output logic          ext_rvalid,
    output logic [31:0]   ext_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_be,
    output logic [63:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata
);
    typedef struct packed {
        logic [31:0] hi;
        logic        irv;
        logic        isel_hi;
        logic [31:0] hrd_data;
        logic        erv;
        logic [31:0] erdata;
    } top_t;

    top_t    t_d, t_q;
    phr_op_e op;
    logic    is_mem, is_int, is_store, is_load, is_phrase;
    logic    ext_req, accept, busy;
    logic    ram_wr, ram_rd;
    logic    ld_done;
    logic [31:0] ld_word, ld_upper, ram_rdata;
    wire     unused_addr_lsbs = ^req_addr[1:0];

    always_comb begin
        op        = phr_op_e'(req_op);
        is_mem    = (op == OP_LD) || (op == OP_ST) || (op == OP_LDP) || (op == OP_STP);
        is_store  = (op == OP_ST) || (op == OP_STP);
        is_load   = (op == OP_LD) || (op == OP_LDP);
        is_phrase = (op == OP_LDP) || (op == OP_STP);
        is_int    = req_addr[AW-1];
        ext_req   = req_valid && is_mem && !is_int;
        stall     = ext_req && busy;
        accept    = req_valid && !stall;
        ram_wr    = accept && is_int && is_store;
        ram_rd    = accept && is_int && is_load;
    end

    phr_int_ram #(.WORDS(INT_WORDS)) u_ram (
        .clk   (clk),
        .wr_en (ram_wr),
        .rd_en (ram_rd),
        .idx   (req_addr[2 +: IW]),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    phr_ext_ctrl #(.AW(AW), .LAUNCH_CYC(LAUNCH_CYC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (ext_req && !busy),
        .start_we     (is_store),
        .start_phrase (is_phrase),
        .start_addr   (req_addr[AW-1:2]),
        .start_data   (req_wdata),
        .hi_word      (t_q.hi),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .ld_done      (ld_done),
        .ld_word      (ld_word),
        .ld_upper     (ld_upper)
    );

    always_comb begin
        t_d         = t_q;
        t_d.irv     = accept && ((op == OP_HRD) || ram_rd);
        t_d.isel_hi = (op == OP_HRD);
        if (accept && op == OP_HRD) t_d.hrd_data = t_q.hi;
        t_d.erv = ld_done;
        if (ld_done) begin
            t_d.erdata = ld_word;
            t_d.hi     = ld_upper;
        end
        // a core write is later in program order than any load completing now
        if (accept && op == OP_HWR) t_d.hi = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign int_rvalid = t_q.irv;
    assign int_rdata  = t_q.isel_hi ? t_q.hrd_data : ram_rdata;
    assign ext_rvalid = t_q.erv;
    assign ext_rdata  = t_q.erdata;
endmodule

// File: rtl/phr_unit_chk.sv
module phr_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          req_int,
    input logic          stall,
    input logic          int_rvalid,
    input logic          ext_rvalid,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   mem_wdata
);
    // R8
    stall_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> req_valid);

    // R7
    int_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_int || req_op >= 3'd4)) |-> !stall);

    // R3
    mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R9
    wdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wdata) && $stable(mem_addr)));

    // R10
    rsv_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op >= 3'd6) |=> !int_rvalid);

    // R2
    hrd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |=> int_rvalid);

    // R4
    ext_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rvalid |-> $past(mem_ack));
endmodule

bind phr_unit phr_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_int    (req_addr[AW-1]),
    .stall      (stall),
    .int_rvalid (int_rvalid),
    .ext_rvalid (ext_rvalid),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/phr_unit_bench.sv
`timescale 1ns/1ps
module phr_unit_bench;
    localparam int AW = 16;
    localparam int ACK_DLY = 2;
    localparam logic [15:0] INT = 16'h8000;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid;
    logic [2:0] req_op;
    logic [AW-1:0] req_addr;
    logic [31:0] req_wdata;
    logic stall, int_rvalid, ext_rvalid, mem_req, mem_we, mem_ack;
    logic [31:0] int_rdata, ext_rdata;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_be;
    logic [63:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    phr_unit #(.AW(AW), .INT_WORDS(16), .LAUNCH_CYC(2)) u_phr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
        .int_rvalid(int_rvalid), .int_rdata(int_rdata),
        .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int tests = 0;
    int fails = 0;

    // external memory model
    logic [63:0] bmem [16];
    logic [63:0] wr_data [256];
    logic [15:0] wr_addr [256];
    logic [7:0]  wr_be   [256];
    int wr_n = 0;
    int acnt = 0;
    int reqs = 0;
    logic mreq_prev = 1'b0;
    assign mem_rdata = bmem[mem_addr[6:3]];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            acnt = 0;
            mreq_prev = 1'b0;
        end else begin
            if (mem_req && !mreq_prev) reqs++;
            mreq_prev = mem_req;
            if (mem_req && mem_ack && mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) bmem[mem_addr[6:3]][8*b +: 8] = mem_wdata[8*b +: 8];
                if (wr_n < 256) begin
                    wr_data[wr_n] = mem_wdata;
                    wr_addr[wr_n] = mem_addr;
                    wr_be[wr_n]   = mem_be;
                end
                wr_n++;
            end
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (acnt == ACK_DLY) begin
                    mem_ack <= 1'b1;
                    acnt = 0;
                end else acnt++;
            end
        end
    end

    // external response monitor
    int ext_n = 0;
    logic [31:0] last_ext;
    always @(negedge clk) if (rst_n && ext_rvalid) begin
        ext_n++;
        last_ext = ext_rdata;
    end

    logic int_seen;
    logic [31:0] int_val;
    int stalls;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic issue(input logic [2:0] op, input logic [15:0] addr, input logic [31:0] data);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = data;
        stalls = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        int_seen = int_rvalid;
        int_val  = int_rdata;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic read_hi(output logic [31:0] v);
        issue(3'd5, 16'h0, 32'h0);
        v = int_val;
    endtask

    function automatic logic [31:0] hv(int p, int lo);
        return 32'hA500_0000 | (p << 8) | lo;
    endfunction
    function automatic logic [31:0] dv(int p, int lo);
        return 32'h3C00_0000 | (p << 12) | (lo << 4) | 32'h3;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] h;
        int n0, r0, e0;
        for (int i = 0; i < 16; i++) bmem[i] = {32'h7100_0000 + i, 32'h0E00_0000 + i};
        rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 stall", {63'b0, stall}, 64'd0);
        chk("R1 mem_req", {63'b0, mem_req}, 64'd0);
        chk("R1 rvalids", {62'b0, int_rvalid, ext_rvalid}, 64'd0);
        read_hi(h);
        chk("R1 hi after reset", {32'b0, h}, 64'd0);

        // R2 high-word write/read
        for (int k = 0; k < 4; k++) begin
            issue(3'd4, 16'h0, 32'h0F0F_0000 ^ (k * 32'h1111_1111));
            chk("R2 hwr no stall", stalls, 0);
            read_hi(h);
            chk("R2 hrd valid", {63'b0, int_seen}, 64'd1);
            chk("R2 hrd value", {32'b0, h}, {32'b0, 32'h0F0F_0000 ^ (k * 32'h1111_1111)});
        end

        // R3 phrase store sweep over phrases and low offsets
        for (int p = 0; p < 8; p++) begin
            for (int lo = 0; lo < 8; lo++) begin
                n0 = wr_n;
                issue(3'd4, 16'h0, hv(p, lo));
                issue(3'd3, 16'(p * 8 + lo), dv(p, lo));
                settle();
                chk("R3 one write", wr_n - n0, 1);
                chk("R3 data", wr_data[n0], {hv(p, lo), dv(p, lo)});
                chk("R3 addr", {48'b0, wr_addr[n0]}, 64'(p * 8));
                chk("R3 be", {56'b0, wr_be[n0]}, 64'hFF);
            end
        end

        // R4 phrase loads
        for (int p = 0; p < 8; p++) begin
            e0 = ext_n;
            issue(3'd4, 16'h0, 32'hFFFF_0000);
            issue(3'd2, 16'(p * 8 + p), 32'h0);
            settle();
            chk("R4 one response", ext_n - e0, 1);
            chk("R4 low word", {32'b0, last_ext}, {32'b0, dv(p, 7)});
            read_hi(h);
            chk("R4 hi gets upper", {32'b0, h}, {32'b0, hv(p, 7)});
        end

        // R5 ordinary loads: lane select and hi overwrite
        issue(3'd4, 16'h0, 32'hDEAD_0001);
        issue(3'd0, 16'(3 * 8 + 4), 32'h0);
        settle();
        chk("R5 upper lane", {32'b0, last_ext}, {32'b0, hv(3, 7)});
        read_hi(h);
        chk("R5 hi overwritten", {32'b0, h}, {32'b0, hv(3, 7)});
        issue(3'd4, 16'h0, 32'hDEAD_0002);
        issue(3'd0, 16'(5 * 8), 32'h0);
        settle();
        chk("R5 lower lane", {32'b0, last_ext}, {32'b0, dv(5, 7)});
        read_hi(h);
        chk("R5 hi overwritten low", {32'b0, h}, {32'b0, hv(5, 7)});

        // R6 ordinary stores on both lanes
        n0 = wr_n;
        issue(3'd1, 16'(2 * 8 + 4), 32'h600D_F00D);
        settle();
        chk("R6 wdata dup", wr_data[n0], {32'h600D_F00D, 32'h600D_F00D});
        chk("R6 be upper", {56'b0, wr_be[n0]}, 64'hF0);
        issue(3'd1, 16'(6 * 8), 32'hBEEF_0606);
        settle();
        chk("R6 be lower", {56'b0, wr_be[n0 + 1]}, 64'h0F);
        issue(3'd0, 16'(2 * 8 + 4), 32'h0);
        settle();
        chk("R6 upper readback", {32'b0, last_ext}, {32'b0, 32'h600D_F00D});
        issue(3'd0, 16'(2 * 8), 32'h0);
        settle();
        chk("R6 lower untouched", {32'b0, last_ext}, {32'b0, dv(2, 7)});

        // R7 internal memory
        issue(3'd4, 16'h0, 32'h1234_5678);
        r0 = reqs;
        for (int k = 0; k < 16; k++) begin
            issue(3'd1, INT | 16'(k * 4), 32'hB000_0000 + k);
            chk("R7 int store no stall", stalls, 0);
        end
        for (int k = 0; k < 16; k++) begin
            issue(3'd0, INT | 16'(k * 4), 32'h0);
            chk("R7 int load one cycle", {63'b0, int_seen}, 64'd1);
            chk("R7 int load value", {32'b0, int_val}, {32'b0, 32'hB000_0000 + k});
        end
        issue(3'd3, INT | 16'h000C, 32'hCAFE_0003);
        issue(3'd2, INT | 16'h000C, 32'h0);
        chk("R7 int phrase load value", {32'b0, int_val}, {32'b0, 32'hCAFE_0003});
        settle();
        chk("R7 no external request", reqs - r0, 0);
        read_hi(h);
        chk("R7 hi unchanged", {32'b0, h}, {32'b0, 32'h1234_5678});

        // R8 stall while busy, ordering preserved
        issue(3'd4, 16'h0, 32'h7777_0008);
        issue(3'd3, 16'(6 * 8), 32'h8888_0008);
        issue(3'd0, INT | 16'h0004, 32'h0);
        chk("R8 internal not stalled", stalls, 0);
        issue(3'd0, 16'(6 * 8), 32'h0);
        chk("R8 external stalled", {63'b0, stalls > 0}, 64'd1);
        settle();
        chk("R8 load sees earlier store", {32'b0, last_ext}, {32'b0, 32'h8888_0008});
        read_hi(h);
        chk("R8 hi from load", {32'b0, h}, {32'b0, 32'h7777_0008});

        // R9 launch-time capture: early hi write reaches the store
        issue(3'd4, 16'h0, 32'h1111_1111);
        n0 = wr_n;
        issue(3'd3, 16'(7 * 8), 32'hD000_0009);
        issue(3'd4, 16'h0, 32'h2222_2222);
        settle();
        chk("R9 early hwr reaches store", wr_data[n0], {32'h2222_2222, 32'hD000_0009});
        // R9 after an intervening external access the hi write cannot reach it
        issue(3'd4, 16'h0, 32'h3333_3333);
        n0 = wr_n;
        issue(3'd3, 16'(1 * 8), 32'hE000_0009);
        issue(3'd1, 16'(4 * 8), 32'hF000_0009);
        issue(3'd4, 16'h0, 32'h4444_4444);
        settle();
        chk("R9 two writes", wr_n - n0, 2);
        chk("R9 late hwr isolated", wr_data[n0], {32'h3333_3333, 32'hE000_0009});
        chk("R9 second is word store", wr_data[n0 + 1], {32'hF000_0009, 32'hF000_0009});

        // R10 reserved op codes
        issue(3'd4, 16'h0, 32'h5555_0010);
        r0 = reqs;
        issue(3'd6, 16'h0010, 32'hAAAA_AAAA);
        chk("R10 op6 no response", {63'b0, int_seen}, 64'd0);
        issue(3'd7, INT | 16'h0010, 32'hAAAA_AAAA);
        chk("R10 op7 no response", {63'b0, int_seen}, 64'd0);
        settle();
        chk("R10 no external request", reqs - r0, 0);
        read_hi(h);
        chk("R10 hi unchanged", {32'b0, h}, {32'b0, 32'h5555_0010});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule